// File: doc/BRIEF.md
# Serial Augmented CRC-16 Engine

This block computes a 16-bit cyclic redundancy remainder one message bit per clock, using the generator x^16 + x^12 + x^5 + 1 (written 0x1021 once the leading term is dropped). The message is treated as a polynomial over GF(2), where addition is XOR. The block uses the augmented division form. After the final data bit, an internal sequencer feeds sixteen zero bits through the register on its own. Only then is the remainder declared valid.

A producer pulses `start` to open a message. It then streams bits over a valid/ready input and flags the final bit with `in_last`. Back-pressure follows the usual rules. A bit transfers on a clock edge where `in_valid` and `in_ready` are both high. The producer holds `in_bit` and `in_last` steady while it waits. `in_ready` is low before the first start, during the sixteen flush cycles, and after the result. When flushing ends, `done` pulses for one cycle and `crc_out` carries the remainder. `crc_out` keeps that value until the next `start`.

Top module: `crc16_aug_serial`

## Requirements
- R1: With the first bit taken as the highest power, `crc_out` at `done` equals M(x)·x^16 mod (x^16 + x^12 + x^5 + 1). For example, the ASCII string "123456789" sent MSB-first per byte gives 0x31C3, and the single bit 1 gives 0x1021.
- R2: While synchronous reset `rst` is high, `in_ready`, `done` and `crc_out` all go to zero on the next edge.
- R3: `start` clears the register to zero and raises `in_ready` on the next cycle, from any state, including mid-message and mid-flush. A bit offered in the same cycle as `start` is not taken, even if `in_last` is set.
- R4: In the load phase, exactly one bit is consumed per edge where `in_valid` and `in_ready` are both high. Cycles with `in_valid` low leave `crc_out` unchanged.
- R5: An accepted bit with `in_last` high ends the input phase. `in_ready` is then low for the sixteen following cycles.
- R6: `done` rises on the 16th clock edge after the edge that accepted the last bit. It stays high for exactly one cycle.
- R7: After `done`, `crc_out` holds its value and `in_ready` stays low until the next `start`.
- R8: A message followed by its own 16-bit remainder (MSB first) produces a remainder of 0x0000.
- R9: Outside the load phase, `in_valid`, `in_bit` and `in_last` have no effect on `crc_out` or `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Clear the register and open a new message |
| in_valid | input | 1 | Producer offers a message bit |
| in_ready | output | 1 | Block accepts a message bit this cycle |
| in_bit | input | 1 | Message bit |
| in_last | input | 1 | Offered bit is the final message bit |
| crc_out | output | 16 | Shift register contents; the remainder once `done` has pulsed |
| done | output | 1 | One-cycle strobe: remainder valid |

## Verification
Two events can fall in the same cycle: `start` and a valid message bit, and `start` and an in-progress flush.

The bench forces the first case by raising `start`, `in_valid`, `in_bit` = 1 and `in_last` together mid-message. It then checks that the register reads zero and that the input is still open, which shows the bit and its last flag were dropped.

For the second case, it raises `start` while the sequencer is still flushing an earlier message. It then requires that no stale `done` appears and that the new message's remainder matches the division model exactly.

// File: rtl/crc16_aug_pkg.sv
package crc16_aug_pkg;
  localparam int CRC_W = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_FLUSH = 2'd2
  } seq_state_e;
endpackage

// File: rtl/crc_div_reg.sv
// Shift-left division register: the incoming bit enters at bit 0, and the
// outgoing MSB is fed back into every position where the generator has a 1.
module crc_div_reg #(
  parameter int         W    = 16,
  parameter logic [W-1:0] POLY = 16'h1021
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] q
);
  logic         fb;
  logic [W-1:0] nxt;

  assign fb = q[W-1];

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic src;
    if (i == 0) begin : g_lsb
      assign src = din;
    end else begin : g_mid
      assign src = q[i-1];
    end
    if (POLY[i]) begin : g_tap
      assign nxt[i] = src ^ fb;
    end else begin : g_plain
      assign nxt[i] = src;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (shift_en) q <= nxt;
  end
endmodule

// File: rtl/crc_flush_count.sv
// Counts the zero-bit flush cycles; flags the final one.
module crc_flush_count #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic final_cycle
);
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (en) cnt <= cnt + 1'b1;
  end

  assign final_cycle = (cnt == CW'(LEN - 1));
endmodule

// File: rtl/crc_seq.sv
// Phase sequencer: idle, accept message bits, flush zeros, strobe done.
module crc_seq
  import crc16_aug_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic in_valid,
  input  logic in_last,
  input  logic flush_final,
  output logic in_ready,
  output logic shift_en,
  output logic zero_sel,
  output logic reg_clr,
  output logic cnt_clr,
  output logic cnt_en,
  output logic done
);
  seq_state_e state_q, state_d;
  logic       take;
  logic       flushing;

  assign in_ready = (state_q == ST_LOAD);
  assign take     = in_ready && in_valid && !start;
  assign flushing = (state_q == ST_FLUSH) && !start;
  assign shift_en = take || flushing;
  assign zero_sel = (state_q == ST_FLUSH);
  assign reg_clr  = start;
  assign cnt_clr  = start || (take && in_last);
  assign cnt_en   = flushing;

  always_comb begin
    state_d = state_q;
    if (start) begin
      state_d = ST_LOAD;
    end else begin
      unique case (state_q)
        ST_LOAD:  if (take && in_last) state_d = ST_FLUSH;
        ST_FLUSH: if (flush_final) state_d = ST_IDLE;
        default:  state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= flushing && flush_final;
    end
  end
endmodule

// File: rtl/crc16_aug_serial.sv
module crc16_aug_serial #(
  parameter int           W    = crc16_aug_pkg::CRC_W,
  parameter logic [W-1:0] POLY = crc16_aug_pkg::CRC_POLY
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         in_bit,
  input  logic         in_last,
  output logic [W-1:0] crc_out,
  output logic         done
);
  logic shift_en, zero_sel, reg_clr, cnt_clr, cnt_en, flush_final;
  logic din;

  assign din = zero_sel ? 1'b0 : in_bit;

  crc_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .in_valid   (in_valid),
    .in_last    (in_last),
    .flush_final(flush_final),
    .in_ready   (in_ready),
    .shift_en   (shift_en),
    .zero_sel   (zero_sel),
    .reg_clr    (reg_clr),
    .cnt_clr    (cnt_clr),
    .cnt_en     (cnt_en),
    .done       (done)
  );

  crc_flush_count #(.LEN(W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .clr        (cnt_clr),
    .en         (cnt_en),
    .final_cycle(flush_final)
  );

  crc_div_reg #(.W(W), .POLY(POLY)) u_reg (
    .clk     (clk),
    .rst     (rst),
    .clr     (reg_clr),
    .shift_en(shift_en),
    .din     (din),
    .q       (crc_out)
  );
endmodule

// File: rtl/crc16_aug_chk.sv
module crc16_aug_chk (
  input logic                            clk,
  input logic                            rst,
  input logic                            start,
  input logic                            in_valid,
  input logic                            in_ready,
  input logic                            in_last,
  input logic [crc16_aug_pkg::CRC_W-1:0] crc_out,
  input logic                            done
);
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (!in_ready && !done && crc_out == '0)); // R2

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    start |=> (crc_out == '0 && in_ready && !done)); // R3

  AST_GAP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid && !start) |=> $stable(crc_out)); // R4

  AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_last && !start) |=> !in_ready); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6

  AST_HOLD_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> ($stable(crc_out) && !in_ready)); // R7
endmodule

bind crc16_aug_serial crc16_aug_chk u_chk (.*);

// File: tb/tb_crc16_aug_serial.sv
module tb_crc16_aug_serial;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, in_valid = 1'b0, in_bit = 1'b0, in_last = 1'b0;
  logic in_ready, done;
  logic [15:0] crc_out;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  crc16_aug_serial dut (
    .clk(clk), .rst(rst), .start(start), .in_valid(in_valid),
    .in_ready(in_ready), .in_bit(in_bit), .in_last(in_last),
    .crc_out(crc_out), .done(done)
  );

  localparam int NV = 5;
  localparam logic [127:0] V_MSG [NV] = '{
    128'h313233343536373839, 128'h1, 128'h0, 128'h0001, 128'h10000};
  localparam int V_LEN [NV] = '{72, 1, 8, 16, 17};
  localparam logic [15:0] V_EXP [NV] = '{16'h31C3, 16'h1021, 16'h0000, 16'h1021, 16'h3730};

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Long division of M(x)*x^16 by the generator, bit by bit.
  function automatic logic [15:0] ref_crc(input logic [127:0] m, input int len);
    logic [15:0] r = '0;
    logic b;
    for (int i = len + 15; i >= 0; i--) begin
      b = (i >= 16) ? m[i-16] : 1'b0;
      r = r[15] ? ({r[14:0], b} ^ 16'h1021) : {r[14:0], b};
    end
    return r;
  endfunction

  // Called at a negedge. Sends len bits MSB first, checks flush timing.
  task automatic run_msg(input logic [127:0] m, input int len, input bit gaps,
                         input bit do_start, output logic [15:0] res);
    int  i;
    bit  bad = 0;
    logic [15:0] held;
    if (do_start) begin
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    i = len - 1;
    while (i >= 0) begin
      if (!in_ready) bad = 1;
      if (gaps && ($urandom % 3 == 0)) begin
        in_valid = 1'b0;
        in_bit = $urandom % 2;
      end else begin
        in_valid = 1'b1;
        in_bit = m[i];
        in_last = (i == 0);
      end
      @(negedge clk);
      if (in_valid) i--;
    end
    in_valid = 1'b0;
    in_last = 1'b0;
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk);
      if (done != (k == 16)) bad = 1;
      if (in_ready) bad = 1;
    end
    res = crc_out;
    held = crc_out;
    @(negedge clk);
    check(!bad, "R5/R6", "ready and done timing around flush", {31'b0, bad}, 32'h0);
    check(!done && crc_out == held && !in_ready, "R7", "hold after done",
          {done, in_ready, crc_out}, {2'b0, held});
  endtask

  logic [15:0] res, exp;
  logic [127:0] m;
  int len;

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "WDOG", "watchdog expired", 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R2: reset state
    repeat (2) @(negedge clk);
    check(!in_ready && !done && crc_out == 16'h0, "R2", "reset outputs",
          {in_ready, done, crc_out}, 0);
    rst = 1'b0;
    @(negedge clk);

    // R9: input before any start is ignored
    in_valid = 1'b1; in_bit = 1'b1; in_last = 1'b1;
    repeat (4) @(negedge clk);
    check(!in_ready && !done && crc_out == 16'h0, "R9", "idle ignores input",
          {in_ready, done, crc_out}, 0);
    in_valid = 1'b0; in_last = 1'b0;

    // R1: table of known remainders
    for (int v = 0; v < NV; v++) begin
      check(ref_crc(V_MSG[v], V_LEN[v]) == V_EXP[v], "R1", "model vs table",
            ref_crc(V_MSG[v], V_LEN[v]), V_EXP[v]);
      run_msg(V_MSG[v], V_LEN[v], v[0], 1'b1, res);
      check(res == V_EXP[v], "R1", "table vector remainder", res, V_EXP[v]);
    end

    // R9: after done, input is ignored
    in_valid = 1'b1; in_bit = 1'b1; in_last = 1'b1;
    repeat (5) @(negedge clk);
    check(!done && !in_ready && crc_out == V_EXP[NV-1], "R9", "post-done input ignored",
          {done, in_ready, crc_out}, {2'b0, V_EXP[NV-1]});
    in_valid = 1'b0; in_last = 1'b0;

    // R1, R4, R8: random messages with gaps, then append own remainder
    for (int n = 0; n < 24; n++) begin
      m = {$urandom, $urandom, $urandom, $urandom};
      len = 1 + ($urandom % 96);
      exp = ref_crc(m, len);
      run_msg(m, len, 1'b1, 1'b1, res);
      check(res == exp, "R4", "random message with gaps", res, exp);
      m = (m << 16) | {112'b0, res};
      run_msg(m, len + 16, n[0], 1'b1, res);
      check(res == 16'h0, "R8", "message plus remainder", res, 0);
    end

    // R3: start collides with an offered last bit mid-message
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    in_valid = 1'b1; in_bit = 1'b1;
    repeat (5) @(negedge clk);
    start = 1'b1; in_last = 1'b1;
    @(negedge clk);
    check(crc_out == 16'h0 && in_ready, "R3", "start beats offered bit",
          {in_ready, crc_out}, {1'b1, 16'h0});
    start = 1'b0; in_valid = 1'b0; in_last = 1'b0;
    run_msg(128'h1, 1, 1'b0, 1'b0, res);
    check(res == 16'h1021, "R3", "message after collision", res, 16'h1021);

    // R3: start aborts a flush in progress
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    in_valid = 1'b1; in_bit = 1'b1; in_last = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    repeat (6) @(negedge clk);
    check(!in_ready, "R5", "flush in progress", in_ready, 0);
    exp = ref_crc(128'h313233343536373839, 72);
    run_msg(128'h313233343536373839, 72, 1'b0, 1'b1, res);
    check(res == exp, "R3", "remainder after aborted flush", res, exp);

    // R2: reset mid-message
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    in_valid = 1'b1; in_bit = 1'b1;
    repeat (20) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(!in_ready && !done && crc_out == 16'h0, "R2", "reset mid-message",
          {in_ready, done, crc_out}, 0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule